// File: doc/BRIEF.md
# Dual-Halfword Instruction Sequencer

This block is the front end of a small accumulator machine whose program memory is 40 bits wide, with two 20-bit instructions packed into each word. It reads one word at a time through a synchronous read port and keeps the whole word. It then issues the upper instruction and after it the lower one, each as a decoded order code and address with a valid strobe. Each word costs a single memory read. The lower instruction comes from a holding register.

A program counter holds the word address and a flag records which half is next. Four order codes redirect control. Two always jump and two jump only when the condition input is high. One of each pair resumes at the upper instruction of the target word. The other fetches the target word but skips its upper instruction and resumes at the lower one. Order codes outside the assigned set are issued with an illegal flag and never redirect control. The condition input carries the accumulator zero/sign result computed elsewhere.

Top module: `dual_half_seq`

## Requirements
- R1: While reset is held, `issue_valid` is 0. After reset is released, the first read is at word address 0, and the first instruction issued is the upper half of that word.
- R2: Each 20-bit instruction is split as follows: bits 19..18 are spare, bits 17..12 are the order code (`op_code`) and bits 11..0 are the address (`op_addr`). Within a word, the upper instruction occupies bits 39..20 and the lower one bits 19..0.
- R3: The two spare bits have no effect on `op_code`, `op_addr`, `op_illegal`, `br_taken` or the sequencing.
- R4: The assigned order codes are 0x00 to 0x10 and 0x20 to 0x23, which makes 21 codes. Every other code is issued with `op_illegal` = 1 and never raises `br_taken`.
- R5: With no taken branch, the upper instruction is issued and then the lower one, both with the same `issue_pc`. The next word is then read at address+1. `mem_rd_en` is asserted once per word.
- R6: `mem_rd_en` is asserted for exactly one cycle. The first instruction of that word is issued in the next cycle. An unbranched lower instruction follows in the cycle after that.
- R7: Code 0x20 always branches. The next read is at `op_addr`, and the upper instruction of that word is issued next.
- R8: Code 0x21 always branches. The next read is at `op_addr`, and only the lower instruction of that word is issued, in the cycle after the read.
- R9: Codes 0x22 (to the upper half) and 0x23 (to the lower half) branch like 0x20 and 0x21, but only when `br_cond` is 1 in their issue cycle. Otherwise execution falls through to the next instruction.
- R10: The word address wraps from 4095 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mem_rd_en | output | 1 | Read strobe to program memory |
| mem_addr | output | 12 | Word address to read |
| mem_rdata | input | 40 | Word returned one cycle after `mem_rd_en` |
| br_cond | input | 1 | Branch condition for codes 0x22/0x23 |
| issue_valid | output | 1 | An instruction is being issued this cycle |
| issue_pc | output | 12 | Word address of the issued instruction |
| issue_lo | output | 1 | 1 when the issued instruction is the lower half |
| op_code | output | 6 | Decoded order code |
| op_addr | output | 12 | Address field |
| op_illegal | output | 1 | Order code is not assigned |
| br_taken | output | 1 | The issued instruction redirects control |

## Verification
A corrupted program counter shows on `mem_addr` at the next read strobe, at most three cycles later. A wrong half-select flag shows in the next issue cycle, on `issue_lo` and on the decoded fields. A stale holding register shows on `op_code` and `op_addr` in the cycle that issues the lower instruction, which is the cycle right after the upper one. The bench runs a looping program that mixes both branch forms from both halves, illegal codes, nonzero spare bits, wrap at the top address and a mid-run reset. A pseudo-random condition stream drives both outcomes of the conditional branches, and every port is compared against a behavioural model on every cycle.

// File: rtl/dhs_pkg.sv
package dhs_pkg;
  localparam int DHS_SPARE_W = 2;
  localparam int DHS_OPC_W   = 6;
  localparam int DHS_ADDR_W  = 12;

  // order code map: plain codes 0..LAST_PLAIN, branches in one aligned group of four
  localparam logic [DHS_OPC_W-1:0] OPC_LAST_PLAIN = 6'h10;
  localparam logic [DHS_OPC_W-1:0] OPC_JMP_HI     = 6'h20;
  localparam logic [DHS_OPC_W-1:0] OPC_JMP_LO     = 6'h21;
  localparam logic [DHS_OPC_W-1:0] OPC_JC_HI      = 6'h22;
  localparam logic [DHS_OPC_W-1:0] OPC_JC_LO      = 6'h23;

  typedef enum logic [1:0] {
    ST_FETCH  = 2'd0,
    ST_FIRST  = 2'd1,
    ST_SECOND = 2'd2
  } seq_state_e;
endpackage

// File: rtl/dhs_rst_sync.sv
module dhs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sn = chain_q[STAGES-1];
endmodule

// File: rtl/dhs_decode.sv
module dhs_decode
  import dhs_pkg::*;
#(
  parameter int OPC_W  = DHS_OPC_W,
  parameter int ADDR_W = DHS_ADDR_W,
  localparam int ORD_W = OPC_W + ADDR_W
) (
  input  logic [ORD_W-1:0]  ord_i,
  output logic [OPC_W-1:0]  opc_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              illegal_o,
  output logic              is_br_o,
  output logic              br_lo_o,
  output logic              br_cnd_o
);
  logic plain;

  always_comb begin
    opc_o     = ord_i[ORD_W-1 -: OPC_W];
    addr_o    = ord_i[ADDR_W-1:0];
    plain     = (opc_o <= OPC_LAST_PLAIN);
    is_br_o   = (opc_o[OPC_W-1:2] == OPC_JMP_HI[OPC_W-1:2]);
    br_lo_o   = is_br_o & opc_o[0];
    br_cnd_o  = is_br_o & opc_o[1];
    illegal_o = !(plain || is_br_o);
  end
endmodule

// File: rtl/dhs_seq_ctrl.sv
module dhs_seq_ctrl
  import dhs_pkg::*;
#(
  parameter int SPARE_W = DHS_SPARE_W,
  parameter int OPC_W   = DHS_OPC_W,
  parameter int ADDR_W  = DHS_ADDR_W,
  localparam int ORD_W  = OPC_W + ADDR_W,
  localparam int HALF_W = SPARE_W + ORD_W,
  localparam int WORD_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst_sn,
  input  logic [WORD_W-1:0] rdata_i,
  input  logic              taken_i,
  input  logic [ADDR_W-1:0] target_i,
  input  logic              tgt_lo_i,
  output logic              rd_en_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              issue_valid_o,
  output logic              issue_lo_o,
  output logic [ADDR_W-1:0] issue_pc_o,
  output logic [ORD_W-1:0]  ord_o
);
  seq_state_e        state_q, state_d;
  logic [ADDR_W-1:0] pc_q, pc_d;
  logic              lo_q, lo_d;
  logic [ORD_W-1:0]  hold_q;
  logic              hold_en;
  logic [ORD_W-1:0]  ord_hi, ord_lo;
  logic              unused_spare_bits;

  assign ord_hi = rdata_i[HALF_W+ORD_W-1 -: ORD_W];
  assign ord_lo = rdata_i[ORD_W-1:0];
  assign unused_spare_bits = ^{rdata_i[WORD_W-1 -: SPARE_W], rdata_i[HALF_W-1 -: SPARE_W]};

  // next-state logic
  always_comb begin
    state_d = state_q;
    pc_d    = pc_q;
    lo_d    = lo_q;
    hold_en = 1'b0;
    unique case (state_q)
      ST_FETCH: state_d = ST_FIRST;
      ST_FIRST: begin
        hold_en = 1'b1;
        if (taken_i) begin
          pc_d = target_i; lo_d = tgt_lo_i; state_d = ST_FETCH;
        end else if (lo_q) begin
          pc_d = pc_q + ADDR_W'(1); lo_d = 1'b0; state_d = ST_FETCH;
        end else begin
          state_d = ST_SECOND;
        end
      end
      ST_SECOND: begin
        state_d = ST_FETCH;
        if (taken_i) begin
          pc_d = target_i; lo_d = tgt_lo_i;
        end else begin
          pc_d = pc_q + ADDR_W'(1); lo_d = 1'b0;
        end
      end
      default: state_d = ST_FETCH;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      state_q <= ST_FETCH;
      pc_q    <= '0;
      lo_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      pc_q    <= pc_d;
      lo_q    <= lo_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)      hold_q <= '0;
    else if (hold_en) hold_q <= ord_lo;
  end

  // outputs
  always_comb begin
    rd_en_o       = (state_q == ST_FETCH);
    addr_o        = pc_q;
    issue_valid_o = (state_q != ST_FETCH);
    issue_lo_o    = (state_q == ST_SECOND) || lo_q;
    issue_pc_o    = pc_q;
    if (state_q == ST_SECOND) ord_o = hold_q;
    else if (lo_q)            ord_o = ord_lo;
    else                      ord_o = ord_hi;
  end

  // R5: a word is read once; no back-to-back reads
  a_r5_fetch_once: assert property (@(posedge clk) disable iff (!rst_sn)
    rd_en_o |=> !rd_en_o);
  // R6: the cycle after a read always issues
  a_r6_issue_after_fetch: assert property (@(posedge clk) disable iff (!rst_sn)
    rd_en_o |=> issue_valid_o);
endmodule

// File: rtl/dual_half_seq.sv
module dual_half_seq
  import dhs_pkg::*;
#(
  parameter int SPARE_W    = DHS_SPARE_W,
  parameter int OPC_W      = DHS_OPC_W,
  parameter int ADDR_W     = DHS_ADDR_W,
  parameter int RST_STAGES = 2,
  localparam int ORD_W     = OPC_W + ADDR_W,
  localparam int WORD_W    = 2 * (SPARE_W + ORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic              br_cond,
  output logic              issue_valid,
  output logic [ADDR_W-1:0] issue_pc,
  output logic              issue_lo,
  output logic [OPC_W-1:0]  op_code,
  output logic [ADDR_W-1:0] op_addr,
  output logic              op_illegal,
  output logic              br_taken
);
  logic             rst_sn;
  logic [ORD_W-1:0] cur_ord;
  logic             dec_is_br, dec_br_lo, dec_br_cnd;

  dhs_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sn(rst_sn)
  );

  dhs_seq_ctrl #(.SPARE_W(SPARE_W), .OPC_W(OPC_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst_sn(rst_sn), .rdata_i(mem_rdata),
    .taken_i(br_taken), .target_i(op_addr), .tgt_lo_i(dec_br_lo),
    .rd_en_o(mem_rd_en), .addr_o(mem_addr),
    .issue_valid_o(issue_valid), .issue_lo_o(issue_lo), .issue_pc_o(issue_pc),
    .ord_o(cur_ord)
  );

  dhs_decode #(.OPC_W(OPC_W), .ADDR_W(ADDR_W)) u_dec (
    .ord_i(cur_ord), .opc_o(op_code), .addr_o(op_addr), .illegal_o(op_illegal),
    .is_br_o(dec_is_br), .br_lo_o(dec_br_lo), .br_cnd_o(dec_br_cnd)
  );

  assign br_taken = issue_valid & dec_is_br & (!dec_br_cnd | br_cond);

  // R4: an unassigned code never redirects control
  a_r4_illegal_no_branch: assert property (@(posedge clk) disable iff (!rst_sn)
    issue_valid && op_illegal |-> !br_taken);
  // R5: unbranched upper half is followed by the lower half of the same word
  a_r5_low_follows_high: assert property (@(posedge clk) disable iff (!rst_sn)
    issue_valid && !issue_lo && !br_taken |=> issue_valid && issue_lo && issue_pc == $past(issue_pc));
  // R7: a taken branch reads the target word next
  a_r7_branch_target: assert property (@(posedge clk) disable iff (!rst_sn)
    issue_valid && br_taken |=> mem_rd_en && mem_addr == $past(op_addr));
  // R8: a taken branch to the lower half issues only that half
  a_r8_lo_skip: assert property (@(posedge clk) disable iff (!rst_sn)
    issue_valid && br_taken && dec_br_lo |=> ##1 issue_valid && issue_lo && issue_pc == $past(op_addr, 2));
  // R9: a conditional branch with a false condition in the upper half falls through
  a_r9_cond_false_falls: assert property (@(posedge clk) disable iff (!rst_sn)
    issue_valid && dec_br_cnd && !br_cond && !issue_lo |=> issue_valid && issue_lo);
endmodule

// File: tb/tb_dual_half_seq.sv
module tb_dual_half_seq;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mem_rd_en;
  logic [11:0] mem_addr;
  logic [39:0] mem_rdata;
  logic        br_cond = 1'b0;
  logic        issue_valid;
  logic [11:0] issue_pc;
  logic        issue_lo;
  logic [5:0]  op_code;
  logic [11:0] op_addr;
  logic        op_illegal;
  logic        br_taken;

  int checks = 0;
  int errors = 0;

  logic [39:0] mem [64];

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_half_seq dut (
    .clk(clk), .rst_n(rst_n), .mem_rd_en(mem_rd_en), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .br_cond(br_cond), .issue_valid(issue_valid),
    .issue_pc(issue_pc), .issue_lo(issue_lo), .op_code(op_code), .op_addr(op_addr),
    .op_illegal(op_illegal), .br_taken(br_taken)
  );

  always @(posedge clk) if (mem_rd_en) mem_rdata <= mem[mem_addr[5:0]];

  function automatic logic [19:0] mk(input int spare, input int opc, input int addr);
    return {spare[1:0], opc[5:0], addr[11:0]};
  endfunction

  // behavioural model
  int m_phase, m_pc, m_rel;
  bit m_lo, m_wrap, m_fresh;
  bit e_valid, e_rd, e_lo, e_ill, e_taken, e_tlo;
  int e_addr, e_opc, e_oaddr, e_spare;
  int cond_taken_n = 0, cond_fall_n = 0, wrap_n = 0, spare_n = 0;

  task automatic calc_expect();
    logic [19:0] h;
    e_rd    = (m_phase == 0);
    e_valid = (m_phase != 0);
    e_addr  = m_pc;
    e_lo    = (m_phase == 2) || m_lo;
    h = (m_phase == 2 || m_lo) ? mem[m_pc % 64][19:0] : mem[m_pc % 64][39:20];
    e_spare = int'(h[19:18]);
    e_opc   = int'(h[17:12]);
    e_oaddr = int'(h[11:0]);
    e_ill   = !((e_opc <= 16) || (e_opc >= 32 && e_opc <= 35));
    e_taken = e_valid && (e_opc >= 32 && e_opc <= 35) && (e_opc < 34 || br_cond);
    e_tlo   = (e_opc == 33 || e_opc == 35);
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase = 0; m_pc = 0; m_lo = 0; m_rel = 0; m_wrap = 0; m_fresh = 1;
    end else if (m_rel < 2) begin
      m_rel++;
    end else begin
      calc_expect();
      case (m_phase)
        0: begin m_phase = 1; m_wrap = 0; m_fresh = 0; end
        default: begin
          if (e_taken) begin
            m_pc = e_oaddr; m_lo = e_tlo; m_phase = 0;
          end else if (m_phase == 1 && !m_lo) begin
            m_phase = 2;
          end else begin
            if (m_pc == 4095) m_wrap = 1;
            m_pc = (m_pc + 1) % 4096; m_lo = 0; m_phase = 0;
          end
        end
      endcase
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    string tg;
    calc_expect();
    if (!rst_n) begin
      chk(issue_valid == 1'b0, "R1", "issue_valid in reset", 64'(issue_valid), 64'd0);
      return;
    end
    chk(issue_valid == e_valid, "R6", "issue_valid", 64'(issue_valid), 64'(e_valid));
    chk(mem_rd_en == e_rd, "R5", "mem_rd_en", 64'(mem_rd_en), 64'(e_rd));
    if (e_rd) begin
      tg = m_wrap ? "R10" : (m_fresh ? "R1" : "R5");
      if (m_wrap) wrap_n++;
      chk(mem_addr == 12'(e_addr), tg, "mem_addr", 64'(mem_addr), 64'(e_addr));
    end
    if (e_valid && issue_valid) begin
      chk(issue_pc == 12'(e_addr) && issue_lo == e_lo, "R5", "issue_pc/lo",
          {issue_pc, 3'b0, issue_lo}, {12'(e_addr), 3'b0, e_lo});
      tg = (e_spare != 0) ? "R3" : "R2";
      if (e_spare != 0) spare_n++;
      chk(op_code == 6'(e_opc) && op_addr == 12'(e_oaddr), tg, "op_code/op_addr",
          {op_code, op_addr}, {6'(e_opc), 12'(e_oaddr)});
      chk(op_illegal == e_ill, "R4", "op_illegal", 64'(op_illegal), 64'(e_ill));
      case (e_opc)
        32: tg = "R7";
        33: tg = "R8";
        34, 35: begin
          tg = "R9";
          if (e_taken) cond_taken_n++; else cond_fall_n++;
        end
        default: tg = "R4";
      endcase
      chk(br_taken == e_taken, tg, "br_taken", 64'(br_taken), 64'(e_taken));
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] lfsr = 16'hACE1;
    foreach (mem[i]) mem[i] = {mk(0, 0, 0), mk(0, 0, 0)};
    mem[0]  = {mk(3, 16'h01, 12'h123), mk(0, 16'h10, 12'hABC)};
    mem[1]  = {mk(0, 16'h11, 12'h005), mk(1, 16'h3F, 12'hFFF)};
    mem[2]  = {mk(2, 16'h05, 12'h321), mk(0, 16'h24, 12'h007)};
    mem[3]  = {mk(0, 16'h20, 12'd10),  mk(0, 16'h00, 12'h000)};
    mem[10] = {mk(1, 16'h21, 12'd12),  mk(0, 16'h3E, 12'h111)};
    mem[12] = {mk(0, 16'h3E, 12'h222), mk(2, 16'h22, 12'd20)};
    mem[13] = {mk(0, 16'h02, 12'h333), mk(0, 16'h20, 12'd20)};
    mem[20] = {mk(3, 16'h23, 12'd30),  mk(0, 16'h20, 12'd40)};
    mem[30] = {mk(0, 16'h3E, 12'h444), mk(0, 16'h03, 12'h555)};
    mem[31] = {mk(0, 16'h20, 12'hFFF), mk(0, 16'h3F, 12'h000)};
    mem[40] = {mk(0, 16'h21, 12'hFFF), mk(0, 16'h06, 12'h666)};
    mem[63] = {mk(1, 16'h04, 12'h777), mk(0, 16'h05, 12'h888)};

    for (int cyc = 0; cyc < 3000; cyc++) begin
      @(negedge clk);
      rst_n = !(cyc < 4 || (cyc >= 1500 && cyc < 1503));
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      br_cond = lfsr[0];
      #1;
      compare();
    end

    chk(cond_taken_n > 0, "R9", "conditional taken seen", 64'(cond_taken_n), 64'd1);
    chk(cond_fall_n > 0, "R9", "conditional fall-through seen", 64'(cond_fall_n), 64'd1);
    chk(wrap_n > 0, "R10", "address wrap seen", 64'(wrap_n), 64'd1);
    chk(spare_n > 0, "R3", "nonzero spare issued", 64'(spare_n), 64'd1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule